// File: doc/BRIEF.md
# Match-Clear Interval Timer with Running Capture

This block is a 16-bit up-counter that advances on a single-cycle tick enable. A free-running prescaler in the system clock domain produces the tick, and software chooses one of three prescaler taps or an externally supplied slow tick pulse. The counter is compared against a programmable limit. On the tick where the count equals the limit, the counter returns to zero on that same tick, and an interrupt line pulses for one system clock. Counting then carries on with no gap, so a limit of N gives a period of N+1 ticks.

An optional running capture copies the live count into a readback register on every tick while it is enabled. The copy is taken on the tick and not on the control write, so a readback is only meaningful after at least one tick has passed since capture was turned on. Software uses the block for periodic interrupts, and uses the capture readback as a sample of elapsed time within the current period.

Top module: `match_timer`

## Requirements
- R1: After reset, `irq` is 0, `cap_value` is 0, the timer is stopped with capture off and tap select 0, the prescaler is 0 and the limit register holds all ones.
- R2: The prescaler counts up by one on every system clock after reset. Tap select 0, 1 and 2 give a tick in every cycle where the low 11, 7 or 3 prescaler bits are all ones, which is once per 2048, 128 or 8 clocks. Select 3 uses the `sub_tick` input as the tick.
- R3: On a tick where the running count equals the limit, the count goes to zero and `irq` is high for exactly the next clock cycle. With limit N, interrupts are N+1 ticks apart.
- R4: The count changes only on ticks while the run bit is set. While the run bit is clear the count is held at zero, so each start begins from zero.
- R5: While running with capture enabled, every tick loads `cap_value` with the count as it was before that tick's update.
- R6: While capture is disabled or the timer is stopped, `cap_value` keeps its last value.
- R7: A write to the limit register is ignored while the run bit is set. It takes effect only while the timer is stopped.
- R8: A write with `wr_addr`=0 targets the limit register. A write with `wr_addr`=1 targets control, with bits [1:0] as the tap select, bit 2 as run and bit 3 as capture enable. Control writes are always accepted.
- R9: A limit of zero makes `irq` pulse on every tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = limit register, 1 = control register |
| wr_data | input | 16 | Write data |
| sub_tick | input | 1 | External slow tick pulse, used when tap select is 3 |
| cap_value | output | 16 | Capture register readback |
| irq | output | 1 | One-cycle interrupt pulse on match-and-clear |

## Verification
The bench measures interrupt spacing at every tap and with a limit of zero. A prescaler tap off by one bit, or a counter that clears one tick late, would give a period that is a multiple of the wrong value. It rewrites the limit while the timer runs, and a design that accepts this write changes the period. Using the external tick, it checks that capture holds the count from before the tick. A design that samples after the increment reads one higher. Capture must also hold while disabled. A restart must capture zero on its first tick, which a design that keeps the old count on stop would fail.

// File: rtl/match_timer_pkg.sv
// Package: shared types for the match-clear timer.
// Assumes the control word occupies the low four bits of a register write.
package match_timer_pkg;

    typedef enum logic [1:0] {
        TAP_SLOW = 2'd0,
        TAP_MID  = 2'd1,
        TAP_FAST = 2'd2,
        TAP_AUX  = 2'd3
    } tap_sel_e;

    typedef struct packed {
        logic     cap_en;
        logic     run;
        tap_sel_e sel;
    } timer_ctrl_t;

    localparam int CTRL_W = $bits(timer_ctrl_t);

endpackage

// File: rtl/mt_tick_gen.sv
// Tick generator: free-running prescaler with three power-of-two taps plus an
// external tick input. Output is a one-clock enable, never a derived clock.
// Assumes SHIFT_SLOW is the largest shift and every shift is at least 1.
module mt_tick_gen
    import match_timer_pkg::*;
#(
    parameter int SHIFT_SLOW = 11,
    parameter int SHIFT_MID  = 7,
    parameter int SHIFT_FAST = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  tap_sel_e sel,
    input  logic     sub_tick,
    output logic     tick
);
    localparam int PW    = SHIFT_SLOW;
    localparam int NTAPS = 3;

    logic [PW-1:0]    presc;
    logic [NTAPS-1:0] tap;

    // Free-running prescaler, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) presc <= '0;
        else        presc <= presc + 1'b1;
    end

    // One tap per divide ratio: all low bits set marks the tick cycle.
    for (genvar g = 0; g < NTAPS; g++) begin : g_tap
        localparam int S = (g == 0) ? SHIFT_SLOW : (g == 1) ? SHIFT_MID : SHIFT_FAST;
        assign tap[g] = &presc[S-1:0];
    end

    // Select the active tick source.
    always_comb begin
        unique case (sel)
            TAP_SLOW: tick = tap[0];
            TAP_MID:  tick = tap[1];
            TAP_FAST: tick = tap[2];
            default:  tick = sub_tick;
        endcase
    end

endmodule

// File: rtl/mt_count_core.sv
// Count core: up-counter with match-and-clear and a registered interrupt pulse.
// Assumes tick is a single-cycle enable. The counter is held at zero when stopped.
module mt_count_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic             irq
);
    logic hit;

    // Match detect against the programmed limit.
    assign hit = (count == limit);

    // Advance, wrap on match, or hold at zero while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) count <= '0;
        else if (tick)      count <= hit ? '0 : count + 1'b1;
    end

    // Interrupt pulse for the cycle following the clearing tick.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= run && tick && hit;
    end

endmodule

// File: rtl/mt_capture.sv
// Capture register: samples the live count on every tick while enabled.
// Assumes count is the value before the same edge's counter update.
module mt_capture #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cap
);
    // Load on enabled ticks, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)    cap <= '0;
        else if (load) cap <= count;
    end

endmodule

// File: rtl/match_timer.sv
// Top: register bank (limit, control) around tick generator, count core and
// capture register. Assumes single-cycle write strobes in the clk domain.
module match_timer
    import match_timer_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int SHIFT_SLOW = 11,
    parameter int SHIFT_MID  = 7,
    parameter int SHIFT_FAST = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             sub_tick,
    output logic [CNT_W-1:0] cap_value,
    output logic             irq
);
    timer_ctrl_t      ctrl_q;
    logic [CNT_W-1:0] limit_q;
    logic [CNT_W-1:0] count;
    logic             tick;
    logic             cap_load;

    // Control register: always writable.
    always_ff @(posedge clk) begin
        if (!rst_n)                ctrl_q <= '0;
        else if (wr_en && wr_addr) ctrl_q <= timer_ctrl_t'(wr_data[CTRL_W-1:0]);
    end

    // Limit register: writes accepted only while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)                               limit_q <= '1;
        else if (wr_en && !wr_addr && !ctrl_q.run) limit_q <= wr_data;
    end

    assign cap_load = ctrl_q.run && ctrl_q.cap_en && tick;

    mt_tick_gen #(
        .SHIFT_SLOW (SHIFT_SLOW),
        .SHIFT_MID  (SHIFT_MID),
        .SHIFT_FAST (SHIFT_FAST)
    ) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (ctrl_q.sel),
        .sub_tick (sub_tick),
        .tick     (tick)
    );

    mt_count_core #(.CNT_W(CNT_W)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctrl_q.run),
        .tick  (tick),
        .limit (limit_q),
        .count (count),
        .irq   (irq)
    );

    mt_capture #(.CNT_W(CNT_W)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cap_load),
        .count (count),
        .cap   (cap_value)
    );

endmodule

// File: rtl/match_timer_chk.sv
// Checker: temporal properties of the match-clear timer, bound to its top.
module match_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             run,
    input logic             cap_en,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] limit,
    input logic [CNT_W-1:0] cap,
    input logic             irq
);
    AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> count == '0 || $past(limit) == '0);                                // R3
    AST_IRQ_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(tick) && $past(run) && $past(count) == $past(limit));        // R3
    AST_STOPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> count == '0);                                                     // R4
    AST_CAP_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run && cap_en) |=> cap == $past(count));                          // R5
    AST_CAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && run && cap_en) |=> $stable(cap));                                // R6
    AST_LIMIT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> $stable(limit));                                                   // R7
endmodule

bind match_timer match_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .run    (ctrl_q.run),
    .cap_en (ctrl_q.cap_en),
    .count  (count),
    .limit  (limit_q),
    .cap    (cap_value),
    .irq    (irq)
);

// File: tb/match_timer_test.sv
module match_timer_test;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic         wr_addr = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         sub_tick = 1'b0;
    logic [W-1:0] cap_value;
    logic         irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    match_timer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sub_tick(sub_tick), .cap_value(cap_value), .irq(irq)
    );

    // Behavioural reference model
    int m_presc, m_sel, m_cnt, m_cmp, m_cap;
    bit m_run, m_cen, m_irq;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_presc = 0; m_sel = 0; m_run = 0; m_cen = 0;
            m_cnt = 0; m_cmp = 65535; m_cap = 0; m_irq = 0;
        end else begin
            int sh, nxt;
            bit t;
            sh = (m_sel == 0) ? 11 : (m_sel == 1) ? 7 : 3;
            t  = (m_sel == 3) ? sub_tick : ((m_presc % (1 << sh)) == (1 << sh) - 1);
            m_irq = 0;
            nxt = m_cnt;
            if (m_run) begin
                if (t) begin
                    if (m_cnt == m_cmp) begin nxt = 0; m_irq = 1; end
                    else nxt = m_cnt + 1;
                    if (m_cen) m_cap = m_cnt;
                end
            end else nxt = 0;
            m_cnt = nxt;
            if (wr_en && !wr_addr && !m_run) m_cmp = wr_data;
            if (wr_en && wr_addr) begin
                m_sel = wr_data[1:0]; m_run = wr_data[2]; m_cen = wr_data[3];
            end
            m_presc = (m_presc + 1) % 2048;
        end
    end

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (irq !== m_irq) begin
                errors++;
                $display("FAIL R3 model irq: actual=%0b expected=%0b", irq, m_irq);
            end
            checks++;
            if (cap_value !== W'(m_cap)) begin
                errors++;
                $display("FAIL R5 model capture: actual=%0d expected=%0d", cap_value, m_cap);
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input bit a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_sub();
        @(negedge clk); sub_tick = 1'b1;
        @(negedge clk); sub_tick = 1'b0;
    endtask

    // Cycles between two successive irq pulses; also checks pulse width.
    task automatic irq_period(input string req, output int cyc);
        int n;
        n = 0;
        while (irq !== 1'b1 && n < 20000) begin @(negedge clk); n++; end
        @(negedge clk);
        check({req, " irq one cycle wide"}, irq, 0);
        cyc = 1;
        while (irq !== 1'b1 && cyc < 20000) begin @(negedge clk); cyc++; end
    endtask

    // Watchdog
    initial begin
        #1_500_000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int p;
        int held;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq after reset", irq, 0);
        check("R1 capture after reset", cap_value, 0);

        // Fast tap, limit 3: period 4 ticks * 8 clocks (R2, R3, R8)
        wr(0, 3);
        wr(1, 4'b1110);
        irq_period("R3", p);
        check("R2 R3 fast tap period", p, 32);

        // Limit write while running is ignored (R7)
        wr(0, 10);
        irq_period("R7", p);
        irq_period("R7", p);
        check("R7 period unchanged", p, 32);

        // Stop: capture holds (R4, R6)
        wr(1, 4'b1010);
        held = cap_value;
        repeat (60) @(negedge clk);
        check("R6 capture held while stopped", cap_value, held);

        // Limit zero: irq every tick (R9)
        wr(0, 0);
        wr(1, 4'b0110);
        irq_period("R9", p);
        check("R9 zero limit period", p, 8);

        // Middle tap, limit 5 (R2)
        wr(1, 4'b0001);
        wr(0, 5);
        wr(1, 4'b0101);
        irq_period("R2", p);
        check("R2 mid tap period", p, 6 * 128);

        // Slow tap, limit 1 (R2)
        wr(1, 4'b0000);
        wr(0, 1);
        wr(1, 4'b0100);
        irq_period("R2", p);
        check("R2 slow tap period", p, 2 * 2048);

        // External tick, capture of pre-update count (R2, R5)
        wr(1, 4'b0011);
        wr(0, 100);
        wr(1, 4'b1111);
        pulse_sub();
        check("R4 first capture after start is zero", cap_value, 0);
        repeat (4) pulse_sub();
        check("R5 capture after five ticks", cap_value, 4);

        // Capture disabled: holds while counting continues (R6)
        wr(1, 4'b0111);
        repeat (3) pulse_sub();
        repeat (5) @(negedge clk);
        check("R6 capture held while disabled", cap_value, 4);
        wr(1, 4'b1111);
        pulse_sub();
        check("R5 capture sees count kept running", cap_value, 8);

        // Restart counts from zero (R4)
        wr(1, 4'b1011);
        wr(1, 4'b1111);
        pulse_sub();
        check("R4 restart captures zero", cap_value, 0);
        check("R3 no irq off-match", irq, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule